// File: doc/BRIEF.md
# Bit-Addressable Output Latch with Demultiplexer Mode

This block holds an eight-bit word that is written one bit at a time. A single serial data bit goes into the cell picked by a three-bit address. All stored bits drive the parallel output at all times, and no input gates that output. Two control inputs choose how the word changes on each clock edge. The first is a write-block input, active high. The second is a clear input, active high. Together they give four modes: write the addressed bit, hold the whole word, clear the whole word, or act as a one-of-eight demultiplexer.

The model is synchronous. Every control input is sampled on the rising edge of the system clock, and the stored word is registered. The clear input is not an asynchronous reset. It combines with write-block to pick between a full clear and the demultiplexer mode. A separate active-low system reset clears the word when the chip is initialised.

Top module: `bit_addr_latch`

## Requirements
- R1: The address selects exactly one storage bit, whose index equals the address value, with address bit 0 as the least significant bit (address 3 touches q[3] only).
- R2: With wr_block=0 and clr=0, the addressed bit takes din at the clock edge and every other bit keeps its value.
- R3: With wr_block=1 and clr=0, no bit changes at the clock edge.
- R4: With wr_block=1 and clr=1, all bits become 0 at the clock edge.
- R5: With wr_block=0 and clr=1, the addressed bit takes din and every other bit becomes 0 at the clock edge, so q is one-hot at the address when din=1 and all-zero when din=0.
- R6: When the demultiplexer mode ends, the word it left stays in place. The unaddressed bits remain 0 and the addressed bit keeps the last din it took, until a later write or clear changes them.
- R7: q changes only at a rising clock edge. A change on the inputs between edges leaves q as it was.
- R8: While rst_n is low at a rising edge, q becomes all zeros, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous system reset, active low |
| din | input | 1 | Serial data bit |
| wr_block | input | 1 | Write block, active high (1 = no write) |
| clr | input | 1 | Clear / demultiplex select, active high |
| addr | input | ADDR_W (3) | Bit select, bit 0 least significant |
| q | output | 2**ADDR_W (8) | Stored word, always driven |

## Verification
Every mode result is due exactly one rising edge after the inputs that request it, because the only register on the path is the storage cell. The bench drives inputs on the falling edge, updates its own model of the mode table for the next rising edge, and compares q on the following falling edge, half a period after that edge. For R7, one check samples q just after new inputs are applied and before the edge, and expects the old word. A long random phase with mixed modes is compared every cycle.

// File: rtl/bal_pkg.sv
package bal_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_CLEAR = 2'd2,
    MODE_DEMUX = 2'd3
  } bal_mode_e;

  // Map of the two control inputs onto the four behaviours.
  function automatic bal_mode_e mode_of(input logic blk, input logic clr);
    bal_mode_e m;
    unique case ({blk, clr})
      2'b00:   m = MODE_WRITE;
      2'b10:   m = MODE_HOLD;
      2'b11:   m = MODE_CLEAR;
      default: m = MODE_DEMUX;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bal_mode_dec.sv
module bal_mode_dec
  import bal_pkg::*;
(
  input  logic      wr_block,
  input  logic      clr,
  output bal_mode_e mode
);
  assign mode = mode_of(wr_block, clr);
endmodule

// File: rtl/bal_addr_dec.sv
module bal_addr_dec #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NBITS-1:0]  sel
);
  for (genvar i = 0; i < NBITS; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/bal_cell.sv
module bal_cell
  import bal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bal_mode_e mode,
  input  logic      sel,
  input  logic      din,
  output logic      q_bit
);
  logic nxt;

  always_comb begin
    unique case (mode)
      MODE_WRITE: nxt = sel ? din : q_bit;
      MODE_HOLD:  nxt = q_bit;
      MODE_CLEAR: nxt = 1'b0;
      default:    nxt = sel & din;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q_bit <= 1'b0;
    else        q_bit <= nxt;
  end
endmodule

// File: rtl/bit_addr_latch.sv
module bit_addr_latch
  import bal_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              wr_block,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr,
  output logic [NBITS-1:0]  q
);
  bal_mode_e        mode;
  logic [NBITS-1:0] sel_vec;
  logic             write_evt;
  logic             hold_evt;
  logic             clear_evt;
  logic             demux_evt;

  bal_mode_dec u_mode (
    .wr_block (wr_block),
    .clr      (clr),
    .mode     (mode)
  );

  bal_addr_dec #(.ADDR_W(ADDR_W)) u_addr (
    .addr (addr),
    .sel  (sel_vec)
  );

  for (genvar i = 0; i < NBITS; i++) begin : g_cell
    bal_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .sel   (sel_vec[i]),
      .din   (din),
      .q_bit (q[i])
    );
  end

  assign write_evt = (mode == MODE_WRITE);
  assign hold_evt  = (mode == MODE_HOLD);
  assign clear_evt = (mode == MODE_CLEAR);
  assign demux_evt = (mode == MODE_DEMUX);

  // R1/R2: the addressed cell takes din
  assert_write_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    write_evt |=> ((q & $past(sel_vec)) == ($past(din) ? $past(sel_vec) : '0)));

  // R1/R2: no other cell moves during a write
  assert_write_others_R1: assert property (@(posedge clk) disable iff (!rst_n)
    write_evt |=> ((q & ~$past(sel_vec)) == ($past(q) & ~$past(sel_vec))));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> $stable(q));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (q == '0));

  assert_demux_R5: assert property (@(posedge clk) disable iff (!rst_n)
    demux_evt |=> ($countones(q) <= 1 && q == ($past(din) ? $past(sel_vec) : '0)));

  assert_sysreset_R8: assert property (@(posedge clk)
    !rst_n |=> (q == '0));

endmodule

// File: tb/tb_bit_addr_latch.sv
`timescale 1ns/1ps
module tb_bit_addr_latch;
  localparam int AW = 3;
  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          din = 1'b0;
  logic          wr_block = 1'b1;
  logic          clr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] q;

  int checks = 0;
  int fails  = 0;
  logic [NB-1:0] model = '0;

  always #2.5 clk = ~clk;

  bit_addr_latch #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .din(din), .wr_block(wr_block),
    .clr(clr), .addr(addr), .q(q)
  );

  task automatic check(input logic [NB-1:0] act, input logic [NB-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: q=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference of the mode table, written from the requirements.
  function automatic logic [NB-1:0] ref_next(input logic [NB-1:0] cur, input int a,
                                             input logic d, input logic blk, input logic c);
    logic [NB-1:0] r = cur;
    if (!blk && !c)      r[a] = d;
    else if (blk && c)   r = '0;
    else if (!blk && c) begin r = '0; r[a] = d; end
    return r;
  endfunction

  // Apply one set of inputs on a falling edge, check on the next falling edge.
  task automatic step(input int a, input logic d, input logic blk, input logic c, input string tag);
    @(negedge clk);
    addr = AW'(a); din = d; wr_block = blk; clr = c;
    model = ref_next(model, a, d, blk, c);
    @(negedge clk);
    check(q, model, tag);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R8: system reset, with inputs asking for a write of 1
    din = 1'b1; wr_block = 1'b0; clr = 1'b0; addr = 3'd6;
    repeat (3) @(negedge clk);
    check(q, 8'h00, "R8 reset");
    @(negedge clk);
    rst_n = 1'b1; wr_block = 1'b1;
    model = '0;

    // R1: address 3 reaches bit 3 only
    step(3, 1'b1, 1'b0, 1'b0, "R1 addr3");
    check(q, 8'h08, "R1 literal");
    // R2: back-to-back writes to different addresses
    step(0, 1'b1, 1'b0, 1'b0, "R2 write0");
    step(7, 1'b1, 1'b0, 1'b0, "R2 write7");
    step(3, 1'b0, 1'b0, 1'b0, "R2 write3 zero");
    check(q, 8'h81, "R2 literal");
    // R3: hold while the address and data change
    step(1, 1'b1, 1'b1, 1'b0, "R3 hold a1");
    step(7, 1'b0, 1'b1, 1'b0, "R3 hold a7");
    check(q, 8'h81, "R3 literal");
    // R7: new inputs between edges leave q alone
    @(negedge clk);
    addr = 3'd4; din = 1'b1; wr_block = 1'b0; clr = 1'b0;
    #1 check(q, 8'h81, "R7 before edge");
    model = ref_next(model, 4, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check(q, 8'h91, "R7 after edge");
    // R4: clear-all
    step(2, 1'b1, 1'b1, 1'b1, "R4 clear");
    check(q, 8'h00, "R4 literal");
    for (int i = 0; i < NB; i++) step(i, 1'b1, 1'b0, 1'b0, "R2 fill");
    check(q, 8'hFF, "R2 filled");
    // R5: demultiplexer
    step(5, 1'b1, 1'b0, 1'b1, "R5 demux a5");
    check(q, 8'h20, "R5 literal");
    step(2, 1'b1, 1'b0, 1'b1, "R5 demux a2");
    check(q, 8'h04, "R5 moved");
    step(2, 1'b0, 1'b0, 1'b1, "R5 demux d0");
    check(q, 8'h00, "R5 zero");
    step(6, 1'b1, 1'b0, 1'b1, "R5 demux a6");
    // R6: after demux ends the word stays
    step(1, 1'b1, 1'b1, 1'b0, "R6 hold after demux");
    check(q, 8'h40, "R6 literal");
    step(1, 1'b1, 1'b0, 1'b0, "R6 write after demux");
    check(q, 8'h42, "R6 write literal");

    // Random mixed traffic, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      int a = $urandom_range(0, NB - 1);
      logic d = 1'($urandom_range(0, 1));
      logic b = ($urandom_range(0, 99) < 35);
      logic c = ($urandom_range(0, 99) < 12);
      string tag;
      if (!b && !c)    tag = "R2 random write";
      else if (b && !c) tag = "R3 random hold";
      else if (b && c)  tag = "R4 random clear";
      else              tag = "R5 random demux";
      step(a, d, b, c, tag);
    end

    // R8: reset in mid-sequence
    step(4, 1'b1, 1'b0, 1'b0, "R2 pre-reset");
    @(negedge clk);
    rst_n = 1'b0; wr_block = 1'b0; clr = 1'b0; din = 1'b1;
    @(negedge clk);
    check(q, 8'h00, "R8 mid reset");
    rst_n = 1'b1; wr_block = 1'b1;
    model = '0;
    step(0, 1'b1, 1'b0, 1'b0, "R2 after reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule